// File: doc/BRIEF.md
# Timed Serial Loader for a Latched Driver

This block sits on the host side of a serial-input, latched output driver. It accepts one parallel word through a valid/ready handshake. It then produces the serial data, shift clock and strobe waveforms that move the word into the driver's shift register and copy it into the driver's latches. The driver shifts on the rising edge of its clock, and the first bit shifted in ends up in the last stage, so the word goes out most significant bit first.

Each interval the driver needs has a minimum in nanoseconds: data setup before the clock edge, data hold after it, data pulse width, clock high width, clock low width, the delay from clock to strobe, and the strobe width. Each minimum is a parameter. It is converted at elaboration into a whole number of system-clock cycles, rounded up, with at least one cycle.

For every bit the loader steps through the same explicit sequence: setup, clock high, then hold with the clock low. After the last bit it waits out the clock-to-strobe gap, raises strobe for its width, and ends with a one-cycle done pulse.

Top module: `serial_drv_loader`

## Requirements
- R1: While rst_ni is low, and right after it rises, ready_o is 1 and sclk_o, sdata_o, strobe_o and done_o are 0.
- R2: A word is accepted on a rising clk_i edge where valid_i and ready_o are both 1. ready_o is 0 from the cycle after acceptance through the done cycle, and is 1 again in the cycle after done_o.
- R3: Each transfer gives exactly WIDTH rising edges on sclk_o. Bit WIDTH-1 of the word is presented first and bit 0 last, so a shift register that captures sdata_o on those edges holds the word.
- R4: sdata_o is stable for at least SETUP_NS before every rising edge of sclk_o.
- R5: sdata_o stays stable for at least HOLD_NS after every rising edge of sclk_o. Each bit stays on sdata_o for at least DATA_NS.
- R6: Within a transfer, every high phase of sclk_o lasts at least CLK_HI_NS and every low phase between two rising edges lasts at least CLK_LO_NS.
- R7: strobe_o rises at least GAP_NS after the last rising edge of sclk_o, and sclk_o is 0 whenever strobe_o is 1.
- R8: Each transfer gives exactly one strobe_o pulse, lasting at least STRB_NS.
- R9: done_o is a single-cycle pulse in the cycle after strobe_o falls. At that point the driver's latches hold the accepted word.
- R10: valid_i and data_i are ignored while a transfer is in progress. The word that is shifted and latched is the one accepted.
- R11: Let S, H, L, D, G and T be ceil(ns / CLK_NS), minimum 1, for setup, hold, clock high, data width, gap and strobe. Let C be the same for clock low. The hold phase lasts Hd = max(H, C-S) cycles. The setup phase lasts Sd = max(S, D-L-Hd) cycles. done_o is high exactly WIDTH*(Sd+L+Hd)+G+T cycles after the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Word offered |
| data_i | input | WIDTH | Word to load into the driver |
| ready_o | output | 1 | Loader idle, word can be accepted |
| sdata_o | output | 1 | Serial data to the driver |
| sclk_o | output | 1 | Shift clock to the driver, rising edge active |
| strobe_o | output | 1 | Latch strobe to the driver, active high |
| done_o | output | 1 | One-cycle pulse when the word is latched |

## Verification
The assertions check on every cycle:
- ready_o drops after acceptance;
- sdata_o changes only when the shift clock has been low for a full cycle;
- strobe is never high with the clock high;
- the clock-high and strobe-high runs reach their minimum cycle counts;
- done is a lone pulse followed by ready.

Only the bench's scenarios can show the rest. These are the bit order and the value left in a model of the driver's latches, the setup, hold, data-width, low-phase and gap distances between separate edges, the exact transfer length, and the fact that a word offered mid-transfer leaves the loaded value unchanged.

// File: rtl/loader_pkg.sv
package loader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_HOLD,
    ST_GAP,
    ST_STRB,
    ST_DONE
  } ld_state_e;

  // ceil(ns / period), never below one cycle
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    if (per == 0) return 1;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // a - b clamped to 1
  function automatic int unsigned usub1(input int unsigned a, input int unsigned b);
    return (a > b) ? (a - b) : 1;
  endfunction

endpackage

// File: rtl/ld_timer.sv
module ld_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= len_i - CNT_W'(1);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired_o = (cnt_q == '0);

  AST_TMR_LEN_NZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (len_i != '0)); // R11

endmodule

// File: rtl/ld_shift.sv
module ld_shift #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             shift_i,
  output logic             sdata_o,
  output logic             last_o
);

  localparam int unsigned BC_W = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] sr_q;
  logic [BC_W-1:0]  bcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      bcnt_q <= '0;
    end else if (load_i) begin
      sr_q   <= data_i;
      bcnt_q <= '0;
    end else if (shift_i) begin
      sr_q   <= {sr_q[WIDTH-2:0], 1'b0};
      bcnt_q <= bcnt_q + BC_W'(1);
    end
  end

  // msb first: first bit in ends in the driver's last stage
  assign sdata_o = sr_q[WIDTH-1];
  assign last_o  = (bcnt_q == BC_W'(WIDTH - 1));

  AST_SHIFT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> (bcnt_q < BC_W'(WIDTH))); // R3

endmodule

// File: rtl/serial_drv_loader.sv
module serial_drv_loader
  import loader_pkg::*;
#(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned CLK_NS    = 10,
  parameter int unsigned SETUP_NS  = 75,
  parameter int unsigned HOLD_NS   = 75,
  parameter int unsigned DATA_NS   = 150,
  parameter int unsigned CLK_HI_NS = 150,
  parameter int unsigned CLK_LO_NS = 150,
  parameter int unsigned GAP_NS    = 30,
  parameter int unsigned STRB_NS   = 100,
  parameter int unsigned CNT_W     = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             ready_o,
  output logic             sdata_o,
  output logic             sclk_o,
  output logic             strobe_o,
  output logic             done_o
);

  localparam int unsigned SETUP_C = ns_to_cyc(SETUP_NS, CLK_NS);
  localparam int unsigned HOLD_C  = ns_to_cyc(HOLD_NS, CLK_NS);
  localparam int unsigned DATA_C  = ns_to_cyc(DATA_NS, CLK_NS);
  localparam int unsigned HI_C    = ns_to_cyc(CLK_HI_NS, CLK_NS);
  localparam int unsigned LO_C    = ns_to_cyc(CLK_LO_NS, CLK_NS);
  localparam int unsigned GAP_C   = ns_to_cyc(GAP_NS, CLK_NS);
  localparam int unsigned STRB_C  = ns_to_cyc(STRB_NS, CLK_NS);
  // low phase = hold + next setup; bit width = setup + high + hold
  localparam int unsigned HOLD_D  = umax(HOLD_C, usub1(LO_C, SETUP_C));
  localparam int unsigned SETUP_D = umax(SETUP_C, usub1(DATA_C, HI_C + HOLD_D));

  localparam logic [CNT_W-1:0] SETUP_L = CNT_W'(SETUP_D);
  localparam logic [CNT_W-1:0] HI_L    = CNT_W'(HI_C);
  localparam logic [CNT_W-1:0] HOLD_L  = CNT_W'(HOLD_D);
  localparam logic [CNT_W-1:0] GAP_L   = CNT_W'(GAP_C);
  localparam logic [CNT_W-1:0] STRB_L  = CNT_W'(STRB_C);
  localparam logic [CNT_W-1:0] ONE_L   = CNT_W'(1);

  if (CLK_NS == 0) begin : g_bad_clk
    $error("serial_drv_loader: CLK_NS must be nonzero");
  end
  if (WIDTH < 2) begin : g_bad_width
    $error("serial_drv_loader: WIDTH must be at least 2");
  end
  if (umax(umax(SETUP_D, HOLD_D), umax(umax(HI_C, GAP_C), STRB_C)) >= (64'd1 << CNT_W))
  begin : g_bad_cnt
    $error("serial_drv_loader: CNT_W too small for a phase length");
  end

  ld_state_e        state_q, state_d;
  logic             t_load, t_exp, sh_load, sh_shift, sh_last;
  logic [CNT_W-1:0] t_len;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (valid_i) state_d = ST_SETUP;
      ST_SETUP: if (t_exp)   state_d = ST_HIGH;
      ST_HIGH:  if (t_exp)   state_d = ST_HOLD;
      ST_HOLD:  if (t_exp)   state_d = sh_last ? ST_GAP : ST_SETUP;
      ST_GAP:   if (t_exp)   state_d = ST_STRB;
      ST_STRB:  if (t_exp)   state_d = ST_DONE;
      ST_DONE:  if (t_exp)   state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_d)
      ST_SETUP: t_len = SETUP_L;
      ST_HIGH:  t_len = HI_L;
      ST_HOLD:  t_len = HOLD_L;
      ST_GAP:   t_len = GAP_L;
      ST_STRB:  t_len = STRB_L;
      default:  t_len = ONE_L;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign t_load   = (state_d != state_q);
  assign sh_load  = (state_q == ST_IDLE) && valid_i;
  assign sh_shift = (state_q == ST_HOLD) && t_exp;

  ld_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (t_load),
    .len_i     (t_len),
    .expired_o (t_exp)
  );

  ld_shift #(.WIDTH(WIDTH)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sh_load),
    .data_i  (data_i),
    .shift_i (sh_shift),
    .sdata_o (sdata_o),
    .last_o  (sh_last)
  );

  assign ready_o  = (state_q == ST_IDLE);
  assign sclk_o   = (state_q == ST_HIGH);
  assign strobe_o = (state_q == ST_STRB);
  assign done_o   = (state_q == ST_DONE);

  // run-length counters for the width checks
  logic [CNT_W-1:0] hi_run_q, strb_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run_q   <= '0;
      strb_run_q <= '0;
    end else begin
      hi_run_q   <= sclk_o   ? hi_run_q + CNT_W'(1)   : '0;
      strb_run_q <= strobe_o ? strb_run_q + CNT_W'(1) : '0;
    end
  end

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ready_o |=> !ready_o); // R2
  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !sclk_o && !strobe_o && !done_o); // R2
  AST_DATA_MOVES_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdata_o) |-> !sclk_o && !$past(sclk_o)); // R5
  AST_CLK_HIGH_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> hi_run_q >= HI_L); // R6
  AST_STRB_CLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_o |-> !sclk_o); // R7
  AST_STRB_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(strobe_o) |-> strb_run_q >= STRB_L); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && ready_o); // R9

endmodule

// File: tb/serial_drv_loader_tb_top.sv
`timescale 1ns/1ps
module serial_drv_loader_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int SETUP_NS = 75, HOLD_NS = 75, DATA_NS = 150;
  localparam int HI_NS = 150, LO_NS = 150, GAP_NS = 30, STRB_NS = 100;
  // R11 expected timing, from the requirement's formulas
  localparam int S  = (SETUP_NS + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int H  = (HOLD_NS + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int L  = (HI_NS + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int C  = (LO_NS + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int D  = (DATA_NS + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int G  = (GAP_NS + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int T  = (STRB_NS + CLK_PERIOD - 1) / CLK_PERIOD;
  localparam int HD = (H > C - S) ? H : C - S;
  localparam int SD = (S > D - L - HD) ? S : D - L - HD;
  localparam int EXP_DONE = W * (SD + L + HD) + G + T;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [W-1:0] data = '0;
  logic ready, sdata, sclk, strobe, done;
  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  serial_drv_loader dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .data_i(data),
    .ready_o(ready), .sdata_o(sdata), .sclk_o(sclk), .strobe_o(strobe), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    valid = 1'b1;
    data  = 8'hFF;
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R1", "ready in reset", ready, 1);
    chk({sclk, sdata, strobe, done} == 4'b0, "R1", "outputs in reset", {sclk, sdata, strobe, done}, 0);
    valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready == 1'b1 && {sclk, sdata, strobe, done} == 4'b0, "R1", "after release",
        {ready, sclk, sdata, strobe, done}, 5'b10000);
  endtask

  // one transfer with a model of the driver; poke keeps offering junk while busy
  task automatic t_xfer(input logic [W-1:0] word, input bit poke, input logic [W-1:0] junk);
    int last_chg = 0, last_rise = 0, last_fall = 0, strb_rise = 0;
    int rises = 0, pulses = 0, done_k = -1;
    bit have_rise = 0, have_fall = 0;
    logic p_sclk, p_sdata, p_strb;
    logic [W-1:0] sr = '0, latch = '0;
    string rq;
    rq = poke ? "R10" : "R3";
    @(negedge clk);
    data = word;
    valid = 1'b1;
    p_sdata = sdata; p_sclk = sclk; p_strb = strobe;
    @(negedge clk);
    chk(ready == 1'b0, "R2", "ready after accept", ready, 0);
    if (poke) data = junk;
    else valid = 1'b0;
    for (int k = 0; k < 4000 && done_k < 0; k++) begin
      if (poke && k == 40) begin
        chk(ready == 1'b0, "R10", "ready while busy", ready, 0);
        valid = 1'b0;
      end
      if (sdata !== p_sdata) begin
        if (have_rise)
          chk((k - last_rise) * CLK_PERIOD >= HOLD_NS, "R5", "hold ns", (k - last_rise) * CLK_PERIOD, HOLD_NS);
        if (k > 0)
          chk((k - last_chg) * CLK_PERIOD >= DATA_NS, "R5", "bit width ns", (k - last_chg) * CLK_PERIOD, DATA_NS);
        last_chg = k;
      end
      if (sclk && !p_sclk) begin
        chk((k - last_chg) * CLK_PERIOD >= SETUP_NS, "R4", "setup ns", (k - last_chg) * CLK_PERIOD, SETUP_NS);
        if (have_fall)
          chk((k - last_fall) * CLK_PERIOD >= LO_NS, "R6", "clock low ns", (k - last_fall) * CLK_PERIOD, LO_NS);
        sr = {sr[W-2:0], sdata};
        rises++;
        last_rise = k;
        have_rise = 1;
      end
      if (!sclk && p_sclk) begin
        chk((k - last_rise) * CLK_PERIOD >= HI_NS, "R6", "clock high ns", (k - last_rise) * CLK_PERIOD, HI_NS);
        last_fall = k;
        have_fall = 1;
      end
      if (strobe && !p_strb) begin
        chk((k - last_rise) * CLK_PERIOD >= GAP_NS, "R7", "clock to strobe ns", (k - last_rise) * CLK_PERIOD, GAP_NS);
        chk(sclk == 1'b0, "R7", "clock low at strobe", sclk, 0);
        strb_rise = k;
        pulses++;
      end
      if (!strobe && p_strb)
        chk((k - strb_rise) * CLK_PERIOD >= STRB_NS, "R8", "strobe width ns", (k - strb_rise) * CLK_PERIOD, STRB_NS);
      if (strobe) latch = sr;
      if (done) begin
        done_k = k;
        chk(p_strb == 1'b1 && strobe == 1'b0, "R9", "done follows strobe", p_strb, 1);
      end
      p_sclk = sclk; p_sdata = sdata; p_strb = strobe;
      if (done_k < 0) @(negedge clk);
    end
    chk(rises == W, "R3", "clock edges", rises, W);
    chk(pulses == 1, "R8", "strobe pulses", pulses, 1);
    chk(latch == word, rq, "latched word", latch, word);
    chk(done_k == EXP_DONE, "R11", "cycles to done", done_k, EXP_DONE);
    @(negedge clk);
    chk(done == 1'b0 && ready == 1'b1, "R9", "done pulse then ready", {done, ready}, 2'b01);
  endtask

  initial begin
    t_reset();
    t_xfer(8'hA5, 1'b0, '0);
    t_xfer(8'h00, 1'b0, '0);
    t_xfer(8'hFF, 1'b0, '0);
    t_xfer(8'h01, 1'b0, '0);
    t_xfer(8'h80, 1'b0, '0);
    t_xfer(8'h3C, 1'b1, 8'hC3);
    t_xfer(8'h5A, 1'b0, '0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog: transfer hung, actual 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule